// File: doc/BRIEF.md
# Display Controller Boot Sequencer

This block brings an attached graphics controller from power-off to a configured state with no help from software. After a start pulse it drives the controller's active-low power-down pin through a timed power cycle. It then issues four host commands, with fixed millisecond pauses between them: wake, select external clock, switch the PLL to 48 MHz, and core reset.

After the reset the sequencer polls the controller's identification byte until the expected code comes back. It then writes a fixed list of nineteen configuration entries. A retry limit on the poll turns a missing controller into an error flag, so the sequence never hangs.

Every transfer goes to a separate SPI transaction engine through a request/acknowledge port. Host commands use one request line and register reads and writes use another. A request stays high, with its fields held, until the engine pulses the shared acknowledge. If a request is still high in the cycle after an acknowledge, it is a new transfer. A single prescaler turns the system clock into millisecond ticks. Its ratio is derived from the `CLK_HZ` parameter, giving `T = CLK_HZ/1000` cycles per millisecond.

States and transitions:
- IDLE, DONE and FAIL go to PD_LOW on `start`.
- PD_LOW goes to PD_HIGH when its timer expires, and PD_HIGH goes to WAKE_CMD when its timer expires.
- WAKE_CMD goes to WAKE_WAIT on acknowledge, and WAKE_WAIT goes to CLK_CMD on expiry.
- CLK_CMD goes to CLK_WAIT on acknowledge, and CLK_WAIT goes to PLL_CMD on expiry.
- PLL_CMD goes to PLL_WAIT on acknowledge, and PLL_WAIT goes to RST_CMD on expiry.
- RST_CMD goes to ID_READ on acknowledge.
- ID_READ goes to CFG_WRITE on a matching acknowledge. It goes to FAIL on the last allowed non-matching acknowledge, and otherwise stays in ID_READ.
- CFG_WRITE goes to DONE on the acknowledge of the last entry.

Top module: `disp_boot_seq`

## Requirements
- R1: After reset, `pwr_n`=1, `hc_req`=0, `ra_req`=0, and `busy`, `done` and `err` are all 0.
- R2: A `start` pulse is acted on only when the block is idle, done or failed. One cycle later `busy`=1 and `pwr_n`=0, and `done` and `err` are 0. A `start` pulse while `busy`=1 has no effect on the sequence.
- R3: `pwr_n` is low for exactly 20*T+1 cycles. It is then high for 20*T+1 cycles before the first host-command request rises.
- R4: Exactly four host commands are issued, in this order: 0x00 (wake), 0x44 (external clock), 0x62 (PLL at 48 MHz), 0x68 (core reset).
- R5: Counted from the acknowledge cycle of a command to the cycle its successor's request rises, the gaps are 20*T+2 after wake, 10*T+2 after the clock command and 10*T+2 after the PLL command.
- R6: A request holds its code, address, data, size and direction until it is acknowledged. `hc_req` and `ra_req` are never high together.
- R7: The identification poll is a read (`ra_write`=0) of size code 0 (1 byte) at `ID_ADDR`. Its request rises one cycle after the core-reset acknowledge. The poll is repeated until `ra_rdata` returns 0x7C at an acknowledge.
- R8: After `MAX_POLL` non-matching reads the block sets `err`=1 and `busy`=0. It issues no write and makes no further requests.
- R9: The configuration writes are entries 0 to 18, in this order, with size codes 0=1 byte, 1=2 bytes, 2=4 bytes:
  - Entries 0 to 9 are display timing words, each of size 1: 548, 43, 480, 0, 41, 292, 12, 272, 0, 10.
  - Entry 10 is PWM frequency 1000 and entry 11 is duty `BL_DUTY` (default 100), both of size 1.
  - Entry 12 is 0x82 and entry 13 is 0x80, both of size 0.
  - Entry 14 is 0x26000007 and entry 15 is 0x00000000, both of size 2.
  - Entry 16 is swap value 1, of size 2.
  - Entry 17 is `PCLK_DIV` (default 5) and entry 18 is 1200, both of size 1.
- R10: Entries 14 and 15 target `DL_BASE` and `DL_BASE`+4. Every other entry i targets `REG_BASE`+4*i.
- R11: One cycle after the acknowledge of the last write, `done`=1 and `busy`=0. `pwr_n` stays 1, and `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that starts the boot sequence |
| pwr_n | output | 1 | Controller power-down pin, active low |
| hc_req | output | 1 | Host-command request |
| hc_code | output | 8 | Host-command byte |
| ra_req | output | 1 | Register-access request |
| ra_write | output | 1 | 1 = write, 0 = read |
| ra_addr | output | 22 | Register-access address |
| ra_wdata | output | 32 | Write data, least significant bytes used |
| ra_size | output | 2 | Transfer size code (0=1, 1=2, 2=4 bytes) |
| xfer_ack | input | 1 | One-cycle completion pulse from the transaction engine |
| ra_rdata | input | 8 | Read byte, valid with `xfer_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Identification poll gave up |

## Verification
Every output is a decode of the registered state. A result therefore shows in the cycle after the edge that samples its cause: `busy` and `pwr_n` one cycle after `start`, `done` one cycle after the last write acknowledge, and the identification read one cycle after the core-reset acknowledge. Timed states last their millisecond count times T plus one cycle. From an acknowledge to the next command request is therefore that span plus one more cycle. The bench runs with T=100 and reads every signal at the falling edge. It stamps acknowledges and request rises with a rising-edge cycle count and compares the differences with these exact figures (2001, 2002, 1002, 1).

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int ADDR_W    = 22;
    localparam int DATA_W    = 32;
    localparam int CFG_COUNT = 19;

    localparam logic [7:0] HC_WAKE     = 8'h00;
    localparam logic [7:0] HC_EXT_CLK  = 8'h44;
    localparam logic [7:0] HC_PLL_48M  = 8'h62;
    localparam logic [7:0] HC_CORE_RST = 8'h68;
    localparam logic [7:0] ID_EXPECT   = 8'h7C;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PD_LOW,
        ST_PD_HIGH,
        ST_WAKE_CMD,
        ST_WAKE_WAIT,
        ST_CLK_CMD,
        ST_CLK_WAIT,
        ST_PLL_CMD,
        ST_PLL_WAIT,
        ST_RST_CMD,
        ST_ID_READ,
        ST_CFG_WRITE,
        ST_DONE,
        ST_FAIL
    } boot_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        size;
    } cfg_entry_t;

endpackage

// File: rtl/dbs_ms_prescaler.sv
module dbs_ms_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: prescaler never passes its divide ratio
    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/dbs_ms_delay.sv
module dbs_ms_delay #(
    parameter int MS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic            tick,
    input  logic [MS_W-1:0] target,
    output logic            expired
);
    logic [MS_W-1:0] ms_q;

    assign expired = run && (ms_q == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (clr || !run) begin
            ms_q <= '0;
        end else if (tick && (ms_q != target)) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    // R5: the millisecond count never runs past the wait being timed
    p_ms_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ms_q <= target));

endmodule

// File: rtl/dbs_cfg_table.sv
module dbs_cfg_table
    import dbs_pkg::*;
#(
    parameter int                IDX_W    = 5,
    parameter logic [ADDR_W-1:0] REG_BASE = 22'h102410,
    parameter logic [ADDR_W-1:0] DL_BASE  = 22'h000000,
    parameter logic [15:0]       BL_DUTY  = 16'd100,
    parameter logic [15:0]       PCLK_DIV = 16'd5
) (
    input  logic [IDX_W-1:0] idx,
    output cfg_entry_t       ent
);
    logic is_dl;

    always_comb begin
        is_dl = (idx == IDX_W'(14)) || (idx == IDX_W'(15));
        if (is_dl) begin
            ent.addr = DL_BASE + ADDR_W'({idx[0], 2'b00});
        end else begin
            ent.addr = REG_BASE + ADDR_W'({idx, 2'b00});
        end
        ent.size = SZ_HALF;
        unique case (idx)
            IDX_W'(0):  ent.data = 32'd548;   // line period
            IDX_W'(1):  ent.data = 32'd43;    // line start offset
            IDX_W'(2):  ent.data = 32'd480;   // visible width
            IDX_W'(3):  ent.data = 32'd0;     // hsync assert
            IDX_W'(4):  ent.data = 32'd41;    // hsync release
            IDX_W'(5):  ent.data = 32'd292;   // frame period
            IDX_W'(6):  ent.data = 32'd12;    // frame start offset
            IDX_W'(7):  ent.data = 32'd272;   // visible height
            IDX_W'(8):  ent.data = 32'd0;     // vsync assert
            IDX_W'(9):  ent.data = 32'd10;    // vsync release
            IDX_W'(10): ent.data = 32'd1000;  // backlight PWM rate
            IDX_W'(11): ent.data = {16'd0, BL_DUTY};
            IDX_W'(12): begin ent.data = 32'h82; ent.size = SZ_BYTE; end
            IDX_W'(13): begin ent.data = 32'h80; ent.size = SZ_BYTE; end
            IDX_W'(14): begin ent.data = 32'h2600_0007; ent.size = SZ_WORD; end
            IDX_W'(15): begin ent.data = 32'h0000_0000; ent.size = SZ_WORD; end
            IDX_W'(16): begin ent.data = 32'd1; ent.size = SZ_WORD; end
            IDX_W'(17): ent.data = {16'd0, PCLK_DIV};
            IDX_W'(18): ent.data = 32'd1200;  // touch threshold
            default:    begin ent.data = '0; ent.size = SZ_BYTE; end
        endcase
    end

endmodule

// File: rtl/disp_boot_seq.sv
module disp_boot_seq
    import dbs_pkg::*;
#(
    parameter int                CLK_HZ    = 100_000_000,
    parameter int                PWR_MS    = 20,
    parameter int                WAKE_MS   = 20,
    parameter int                SETTLE_MS = 10,
    parameter int                MAX_POLL  = 8,
    parameter logic [ADDR_W-1:0] ID_ADDR   = 22'h102400,
    parameter logic [ADDR_W-1:0] REG_BASE  = 22'h102410,
    parameter logic [ADDR_W-1:0] DL_BASE   = 22'h000000,
    parameter logic [15:0]       BL_DUTY   = 16'd100,
    parameter logic [15:0]       PCLK_DIV  = 16'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              pwr_n,
    output logic              hc_req,
    output logic [7:0]        hc_code,
    output logic              ra_req,
    output logic              ra_write,
    output logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_wdata,
    output logic [1:0]        ra_size,
    input  logic              xfer_ack,
    input  logic [7:0]        ra_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int TICKS_PER_MS = (CLK_HZ >= 2000) ? CLK_HZ / 1000 : 1;
    localparam int MAX_A        = (PWR_MS > WAKE_MS) ? PWR_MS : WAKE_MS;
    localparam int MAX_MS       = (MAX_A > SETTLE_MS) ? MAX_A : SETTLE_MS;
    localparam int MS_W         = $clog2(MAX_MS + 1);
    localparam int TRY_W        = $clog2(MAX_POLL + 1);
    localparam int IDX_W        = $clog2(CFG_COUNT + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_COUNT - 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_POLL - 1);

    boot_state_t      state_q, state_d;
    logic [MS_W-1:0]  wait_ms;
    logic             timed, tick, expired, tmr_clr;
    logic [IDX_W-1:0] idx_q;
    logic [TRY_W-1:0] tries_q;
    logic             id_ok, restart;
    cfg_entry_t       ent;

    assign id_ok   = (ra_rdata == ID_EXPECT);
    assign restart = start && (state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
    assign tmr_clr = (state_d != state_q);

    dbs_ms_prescaler #(.DIV(TICKS_PER_MS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timed),
        .clr   (tmr_clr),
        .tick  (tick)
    );

    dbs_ms_delay #(.MS_W(MS_W)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timed),
        .clr     (tmr_clr),
        .tick    (tick),
        .target  (wait_ms),
        .expired (expired)
    );

    dbs_cfg_table #(
        .IDX_W    (IDX_W),
        .REG_BASE (REG_BASE),
        .DL_BASE  (DL_BASE),
        .BL_DUTY  (BL_DUTY),
        .PCLK_DIV (PCLK_DIV)
    ) u_table (
        .idx (idx_q),
        .ent (ent)
    );

    // wait length for each timed state
    always_comb begin
        timed   = 1'b1;
        wait_ms = '0;
        unique case (state_q)
            ST_PD_LOW, ST_PD_HIGH:    wait_ms = MS_W'(PWR_MS);
            ST_WAKE_WAIT:             wait_ms = MS_W'(WAKE_MS);
            ST_CLK_WAIT, ST_PLL_WAIT: wait_ms = MS_W'(SETTLE_MS);
            default:                  timed   = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start)    state_d = ST_PD_LOW;
            ST_PD_LOW:                 if (expired)  state_d = ST_PD_HIGH;
            ST_PD_HIGH:                if (expired)  state_d = ST_WAKE_CMD;
            ST_WAKE_CMD:               if (xfer_ack) state_d = ST_WAKE_WAIT;
            ST_WAKE_WAIT:              if (expired)  state_d = ST_CLK_CMD;
            ST_CLK_CMD:                if (xfer_ack) state_d = ST_CLK_WAIT;
            ST_CLK_WAIT:               if (expired)  state_d = ST_PLL_CMD;
            ST_PLL_CMD:                if (xfer_ack) state_d = ST_PLL_WAIT;
            ST_PLL_WAIT:               if (expired)  state_d = ST_RST_CMD;
            ST_RST_CMD:                if (xfer_ack) state_d = ST_ID_READ;
            ST_ID_READ: begin
                if (xfer_ack) begin
                    if (id_ok)                     state_d = ST_CFG_WRITE;
                    else if (tries_q == LAST_TRY)  state_d = ST_FAIL;
                end
            end
            ST_CFG_WRITE: if (xfer_ack && (idx_q == LAST_IDX)) state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // entry index and poll counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            tries_q <= '0;
        end else if (restart) begin
            idx_q   <= '0;
            tries_q <= '0;
        end else if ((state_q == ST_CFG_WRITE) && xfer_ack) begin
            idx_q   <= idx_q + 1'b1;
        end else if ((state_q == ST_ID_READ) && xfer_ack && !id_ok) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        pwr_n    = (state_q != ST_PD_LOW);
        hc_req   = 1'b0;
        hc_code  = 8'h00;
        ra_req   = 1'b0;
        ra_write = 1'b0;
        ra_addr  = ID_ADDR;
        ra_wdata = '0;
        ra_size  = SZ_BYTE;
        busy     = !(state_q inside {ST_IDLE, ST_DONE, ST_FAIL});
        done     = (state_q == ST_DONE);
        err      = (state_q == ST_FAIL);
        unique case (state_q)
            ST_WAKE_CMD: begin hc_req = 1'b1; hc_code = HC_WAKE;     end
            ST_CLK_CMD:  begin hc_req = 1'b1; hc_code = HC_EXT_CLK;  end
            ST_PLL_CMD:  begin hc_req = 1'b1; hc_code = HC_PLL_48M;  end
            ST_RST_CMD:  begin hc_req = 1'b1; hc_code = HC_CORE_RST; end
            ST_ID_READ:  ra_req = 1'b1;
            ST_CFG_WRITE: begin
                ra_req   = 1'b1;
                ra_write = 1'b1;
                ra_addr  = ent.addr;
                ra_wdata = ent.data;
                ra_size  = ent.size;
            end
            default: ;
        endcase
    end

    // R6: the two request kinds never overlap
    p_one_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hc_req && ra_req));

    // R6: a host command holds until acknowledged
    p_hc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hc_req && !xfer_ack) |=> (hc_req && $stable(hc_code)));

    // R6: a register access holds all fields until acknowledged
    p_ra_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_req && !xfer_ack) |=> (ra_req && $stable(ra_addr) && $stable(ra_wdata)
                                   && $stable(ra_size) && $stable(ra_write)));

    // R3: the power-down pin is only low during an active sequence
    p_pwr_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |-> busy);

    // R7: a matching identification read leads straight into writes
    p_id_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_req && !ra_write && xfer_ack && (ra_rdata == ID_EXPECT)) |=> ra_write);

    // R8: a failed boot issues no requests
    p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!hc_req && !ra_req && !busy));

    // R11: completion and failure are exclusive
    p_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

// File: tb/tb_disp_boot_seq.sv
module tb_disp_boot_seq;

    localparam int T        = 100;
    localparam int MAX_POLL = 6;
    localparam logic [21:0] ID_ADDR  = 22'h102400;
    localparam logic [21:0] REG_BASE = 22'h102410;
    localparam logic [21:0] DL_BASE  = 22'h000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pwr_n, hc_req, ra_req, ra_write, busy, done, err;
    logic [7:0]  hc_code;
    logic [21:0] ra_addr;
    logic [31:0] ra_wdata;
    logic [1:0]  ra_size;
    logic        xfer_ack = 1'b0;
    logic [7:0]  ra_rdata = 8'h00;

    always #5 clk = ~clk;

    disp_boot_seq #(
        .CLK_HZ   (T * 1000),
        .MAX_POLL (MAX_POLL),
        .ID_ADDR  (ID_ADDR),
        .REG_BASE (REG_BASE),
        .DL_BASE  (DL_BASE)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .pwr_n    (pwr_n),
        .hc_req   (hc_req),
        .hc_code  (hc_code),
        .ra_req   (ra_req),
        .ra_write (ra_write),
        .ra_addr  (ra_addr),
        .ra_wdata (ra_wdata),
        .ra_size  (ra_size),
        .xfer_ack (xfer_ack),
        .ra_rdata (ra_rdata),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // engine model and logs
    int lat = 3;
    int bad_n = 0;
    int cnt = 0;
    int hc_n, wr_n, rd_n, hc_rise_n, rd_bad, both_err, stab_err, pwr_low_cnt;
    int pwr_rise_cyc, rd_rise_cyc, last_wr_cyc, done_cyc, req_after_err;
    int hc_code_log [0:15];
    int hc_ack_cyc  [0:15];
    int hc_rise_cyc [0:15];
    logic [21:0] wr_addr [0:31];
    logic [31:0] wr_data [0:31];
    logic [1:0]  wr_size [0:31];
    logic pwr_prev, hc_prev, ra_prev, done_prev, ack_was;
    logic [7:0]  code_prev;
    logic [21:0] addr_prev;
    logic [31:0] data_prev;
    logic [1:0]  size_prev;
    logic        wr_prev;

    always @(posedge clk) cyc++;

    task automatic clear_logs();
        hc_n = 0; wr_n = 0; rd_n = 0; hc_rise_n = 0; rd_bad = 0; both_err = 0;
        stab_err = 0; pwr_low_cnt = 0; pwr_rise_cyc = -1; rd_rise_cyc = -1;
        last_wr_cyc = -1; done_cyc = -1; req_after_err = 0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_ack = 1'b0; cnt = 0;
            pwr_prev = 1'b1; hc_prev = 1'b0; ra_prev = 1'b0; done_prev = 1'b0;
        end else begin
            ack_was = xfer_ack;
            if (!pwr_n) pwr_low_cnt++;
            if (pwr_n && !pwr_prev) pwr_rise_cyc = cyc;
            if (hc_req && !hc_prev && hc_rise_n < 16) begin
                hc_rise_cyc[hc_rise_n] = cyc; hc_rise_n++;
            end
            if (ra_req && !ra_prev && rd_rise_cyc < 0) rd_rise_cyc = cyc;
            if (done && !done_prev) done_cyc = cyc;
            if (err && (hc_req || ra_req)) req_after_err++;
            if (hc_req && hc_prev && !ack_was && hc_code != code_prev) stab_err++;
            if (ra_req && ra_prev && !ack_was &&
                (ra_addr != addr_prev || ra_wdata != data_prev ||
                 ra_size != size_prev || ra_write != wr_prev)) stab_err++;
            if (hc_req && ra_req) both_err++;
            if (xfer_ack) begin
                xfer_ack = 1'b0; cnt = 0;
            end else if (hc_req || ra_req) begin
                if (cnt >= lat - 1) begin
                    xfer_ack = 1'b1;
                    if (hc_req) begin
                        if (hc_n < 16) begin
                            hc_code_log[hc_n] = int'(hc_code); hc_ack_cyc[hc_n] = cyc;
                        end
                        hc_n++;
                    end else if (ra_write) begin
                        if (wr_n < 32) begin
                            wr_addr[wr_n] = ra_addr; wr_data[wr_n] = ra_wdata;
                            wr_size[wr_n] = ra_size;
                        end
                        last_wr_cyc = cyc; wr_n++;
                    end else begin
                        if (ra_addr != ID_ADDR || ra_size != 2'd0) rd_bad++;
                        ra_rdata = (rd_n >= bad_n) ? 8'h7C : 8'h5A;
                        rd_n++;
                    end
                end else begin
                    cnt++;
                end
            end
            pwr_prev = pwr_n; hc_prev = hc_req; ra_prev = ra_req; done_prev = done;
            code_prev = hc_code; addr_prev = ra_addr; data_prev = ra_wdata;
            size_prev = ra_size; wr_prev = ra_write;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(input int i);
        case (i)
            0: return 548;  1: return 43;   2: return 480; 3: return 0;
            4: return 41;   5: return 292;  6: return 12;  7: return 272;
            8: return 0;    9: return 10;   10: return 1000; 11: return 100;
            12: return 32'h82; 13: return 32'h80; 14: return 32'h2600_0007;
            15: return 0;   16: return 1;   17: return 5;  default: return 1200;
        endcase
    endfunction

    function automatic logic [1:0] exp_size(input int i);
        if (i == 12 || i == 13) return 2'd0;
        if (i >= 14 && i <= 16) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [21:0] exp_addr(input int i);
        if (i == 14) return DL_BASE;
        if (i == 15) return DL_BASE + 22'd4;
        return REG_BASE + 22'(4 * i);
    endfunction

    task automatic do_reset();
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 40000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic check_writes();
        check(wr_n == 19, "R9 write count", wr_n, 19);
        for (int i = 0; i < 19 && i < wr_n; i++) begin
            check(wr_data[i] == exp_data(i), $sformatf("R9 data entry %0d", i), wr_data[i], exp_data(i));
            check(wr_size[i] == exp_size(i), $sformatf("R9 size entry %0d", i), wr_size[i], exp_size(i));
            check(wr_addr[i] == exp_addr(i), $sformatf("R10 addr entry %0d", i), wr_addr[i], exp_addr(i));
        end
    endtask

    task automatic test_reset();
        do_reset();
        check(pwr_n == 1'b1, "R1 pwr_n", pwr_n, 1);
        check(hc_req == 1'b0 && ra_req == 1'b0, "R1 requests", hc_req | ra_req, 0);
        check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags", {busy, done, err}, 0);
    endtask

    task automatic test_nominal();
        do_reset(); clear_logs(); bad_n = 0;
        pulse_start();
        check(busy == 1'b1 && pwr_n == 1'b0, "R2 start response", {busy, pwr_n}, 2);
        wait_end();
        check(pwr_low_cnt == 20 * T + 1, "R3 pwr_n low length", pwr_low_cnt, 20 * T + 1);
        check(hc_rise_cyc[0] - pwr_rise_cyc == 20 * T + 1, "R3 high before wake",
              hc_rise_cyc[0] - pwr_rise_cyc, 20 * T + 1);
        check(hc_n == 4, "R4 host command count", hc_n, 4);
        check(hc_code_log[0] == 8'h00, "R4 code 0", hc_code_log[0], 8'h00);
        check(hc_code_log[1] == 8'h44, "R4 code 1", hc_code_log[1], 8'h44);
        check(hc_code_log[2] == 8'h62, "R4 code 2", hc_code_log[2], 8'h62);
        check(hc_code_log[3] == 8'h68, "R4 code 3", hc_code_log[3], 8'h68);
        check(hc_rise_cyc[1] - hc_ack_cyc[0] == 20 * T + 2, "R5 wake gap",
              hc_rise_cyc[1] - hc_ack_cyc[0], 20 * T + 2);
        check(hc_rise_cyc[2] - hc_ack_cyc[1] == 10 * T + 2, "R5 clock gap",
              hc_rise_cyc[2] - hc_ack_cyc[1], 10 * T + 2);
        check(hc_rise_cyc[3] - hc_ack_cyc[2] == 10 * T + 2, "R5 pll gap",
              hc_rise_cyc[3] - hc_ack_cyc[2], 10 * T + 2);
        check(stab_err == 0, "R6 request stability", stab_err, 0);
        check(both_err == 0, "R6 request overlap", both_err, 0);
        check(rd_n == 1 && rd_bad == 0, "R7 single id read", rd_n, 1);
        check(rd_rise_cyc - hc_ack_cyc[3] == 1, "R7 read after reset",
              rd_rise_cyc - hc_ack_cyc[3], 1);
        check_writes();
        check(done_cyc - last_wr_cyc == 1, "R11 done timing", done_cyc - last_wr_cyc, 1);
        check(done && !busy && !err && pwr_n, "R11 final flags", {done, busy, err, pwr_n}, 4'b1001);
    endtask

    task automatic test_slow_id();
        do_reset(); clear_logs(); bad_n = 3; lat = 1;
        pulse_start();
        wait_end();
        check(rd_n == 4 && rd_bad == 0, "R7 polls until match", rd_n, 4);
        check(wr_n == 19, "R9 writes after late id", wr_n, 19);
        check(done == 1'b1 && err == 1'b0, "R11 done after late id", done, 1);
        check(stab_err == 0 && both_err == 0, "R6 handshake with short latency", stab_err + both_err, 0);
        lat = 3;
    endtask

    task automatic test_id_timeout();
        do_reset(); clear_logs(); bad_n = 1000;
        pulse_start();
        wait_end();
        check(rd_n == MAX_POLL, "R8 read count at limit", rd_n, MAX_POLL);
        check(err == 1'b1 && busy == 1'b0 && done == 1'b0, "R8 error flags", {err, busy, done}, 3'b100);
        check(wr_n == 0, "R8 no writes", wr_n, 0);
        repeat (50) @(negedge clk);
        check(req_after_err == 0 && rd_n == MAX_POLL, "R8 quiet after error", req_after_err, 0);
        pulse_start();
        check(busy == 1'b1 && err == 1'b0 && pwr_n == 1'b0, "R2 restart from error",
              {busy, err, pwr_n}, 3'b100);
    endtask

    task automatic test_start_ignored();
        do_reset(); clear_logs(); bad_n = 0;
        pulse_start();
        while (hc_n < 1) @(negedge clk);
        pulse_start();
        check(pwr_n == 1'b1, "R2 start ignored while busy", pwr_n, 1);
        wait_end();
        check(pwr_low_cnt == 20 * T + 1, "R2 single power cycle", pwr_low_cnt, 20 * T + 1);
        check(hc_n == 4 && wr_n == 19 && done == 1'b1, "R2 sequence unchanged", hc_n, 4);
        pulse_start();
        check(busy == 1'b1 && done == 1'b0 && pwr_n == 1'b0, "R2 restart from done",
              {busy, done, pwr_n}, 3'b100);
    endtask

    initial begin
        clear_logs();
        test_reset();
        test_nominal();
        test_slow_id();
        test_id_timeout();
        test_start_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule